// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns an address arriving from the PCI side into the system address that a DMA access should use. Software programs four windows through a 64-bit register port. Each window holds three values: a base that carries the enable and mode bits, a size mask, and a target base. A translation request presents one bus address. The block compares that address against every window in parallel and takes the first enabled window that matches.

A matching window in direct mode replaces the upper address bits with the target base and answers on the next cycle. A matching window in scatter-gather mode computes the address of a 64-bit page-table entry. It reads that entry through a valid/ready memory request port, waits for the read data, and builds the page address from it. When no enabled window matches, the address passes through unchanged.

Requests, responses and memory reads all follow valid/ready rules. The block accepts a request only when it is idle. It holds a response, with its address, until the consumer takes it. It holds a memory request, with its address, until the memory accepts it. The memory read data has no back-pressure: the block always takes it while it is waiting for an entry.

Top module: `dma_window_xlate`

## Requirements
- R1: After reset, all twelve window registers read as zero, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The register index is `reg_addr[11:6]`, and the low six address bits are ignored. Indices 0–3 hold the bases of windows 0–3, indices 4–7 hold their masks, and indices 8–11 hold their target bases. Any other index reads as zero, and a write to it changes no register.
- R3: A window matches when the bus address and the window base agree on every bit of 31:20 that is clear in the window mask. Mask bits outside 31:20 have no effect on the compare.
- R4: Bit 0 of a window base enables the window. The lowest-numbered window that is enabled and matches is used. A matching window that is disabled is skipped.
- R5: Direct mode (base bit 1 = 0): let F be mask bits 31:20 and K = F | 0xFFFFF. The result is (target & ~K) | (bus & K).
- R6: Scatter-gather mode (base bit 1 = 1): the block issues one memory request. Its address is (target & ~((F >> 10) | 0x3FF)) | ((bus & (F | 0xFE000)) >> 10). Valid and address stay constant until `mem_req_ready`.
- R7: In scatter-gather mode, the result is ((entry & ~1) << 12) | (bus & 0x1FFF).
- R8: Direct and scatter-gather results are truncated to their low 34 bits.
- R9: With no enabled matching window, `rsp_addr` equals the request address, all 64 bits.
- R10: Direct and pass-through responses are valid in the cycle after acceptance. A scatter-gather response is valid in the cycle after `mem_rsp_valid`.
- R11: `req_ready` is low from acceptance until the response handshake completes. While `rsp_ready` is low, `rsp_valid` and `rsp_addr` hold.
- R12: A register write made while a translation is in flight does not change that translation's result. It does apply to the next translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset in the register space |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational on `reg_addr` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator idle, request accepted |
| req_addr | input | 64 | Bus address to translate |
| rsp_valid | output | 1 | Translated address valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 64 | Translated address |
| mem_req_valid | output | 1 | Page-table entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 64 | Page-table entry address |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Page-table entry |

## Verification
Translation is tried with five kinds of address. One hits no window; it separates pass-through from any mapping and shows that bits above 33 survive. One hits a single direct window; it checks the rebasing arithmetic. One hits two windows at once, first with both enabled and then with the lower one disabled; it tells priority apart from fall-through. One hits a window whose target base and mask have bits above 33 and above 31 set; it isolates truncation and the 31:20 limit. One hits a scatter-gather window, first with an idle memory and then with a stalled one; it checks the entry address, the entry-to-page arithmetic and the hold rules. A final scatter-gather run rewrites the window while the entry is pending. It separates a snapshot taken at acceptance from a live read of the registers.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  localparam int unsigned WORD_W = 64;
  typedef logic [WORD_W-1:0] word_t;

  // bit positions inside a window base
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned MODE_BIT = 1;

  // address arithmetic constants
  localparam word_t CMP_FIELD    = 64'h0000_0000_FFF0_0000;
  localparam word_t DIRECT_LOW   = 64'h0000_0000_000F_FFFF;
  localparam word_t PTE_LOW      = 64'h0000_0000_0000_03FF;
  localparam word_t SG_PAGE_BITS = 64'h0000_0000_000F_E000;
  localparam word_t SG_OFFS      = 64'h0000_0000_0000_1FFF;
  localparam int unsigned PTE_SHIFT  = 10;
  localparam int unsigned PAGE_SHIFT = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_RESP} xl_state_e;

  typedef struct packed {
    logic  hit;
    logic  sg;
    word_t direct_addr;
    word_t pte_addr;
  } match_t;
endpackage

// File: rtl/dxl_regs.sv
module dxl_regs
  import dxl_pkg::*;
#(
  parameter int unsigned NWIN    = 4,
  parameter int unsigned SPACE_W = 12,
  parameter int unsigned IDX_LSB = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [SPACE_W-1:0] addr,
  input  word_t              wdata,
  output word_t              rdata,
  output word_t              win_base  [NWIN],
  output word_t              win_mask  [NWIN],
  output word_t              win_tbase [NWIN]
);
  localparam int unsigned IDX_W  = SPACE_W - IDX_LSB;
  localparam int unsigned SEL_W  = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int unsigned KIND_W = IDX_W - SEL_W;
  localparam logic [KIND_W-1:0] K_BASE  = KIND_W'(0);
  localparam logic [KIND_W-1:0] K_MASK  = KIND_W'(1);
  localparam logic [KIND_W-1:0] K_TBASE = KIND_W'(2);

  logic [IDX_W-1:0]  idx;
  logic [SEL_W-1:0]  sel;
  logic [KIND_W-1:0] kind;
  logic              sel_ok;
  logic              kind_ok;

  assign idx     = addr[SPACE_W-1:IDX_LSB];
  assign sel     = idx[SEL_W-1:0];
  assign kind    = idx[IDX_W-1:SEL_W];
  assign sel_ok  = (32'(sel) < NWIN);
  assign kind_ok = (kind == K_BASE) || (kind == K_MASK) || (kind == K_TBASE);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_base[w]  <= '0;
        win_mask[w]  <= '0;
        win_tbase[w] <= '0;
      end else if (we && sel == SEL_W'(w)) begin
        if (kind == K_BASE)  win_base[w]  <= wdata;
        if (kind == K_MASK)  win_mask[w]  <= wdata;
        if (kind == K_TBASE) win_tbase[w] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ok) begin
      if (kind == K_BASE)  rdata = win_base[sel];
      if (kind == K_MASK)  rdata = win_mask[sel];
      if (kind == K_TBASE) rdata = win_tbase[sel];
    end
  end

  assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !(sel_ok && kind_ok)) |=>
      ($stable(win_base[0]) && $stable(win_mask[0]) && $stable(win_tbase[0])));
endmodule

// File: rtl/dxl_match.sv
module dxl_match
  import dxl_pkg::*;
#(
  parameter int unsigned NWIN  = 4,
  parameter int unsigned OUT_W = 34
) (
  input  word_t  bus,
  input  word_t  win_base  [NWIN],
  input  word_t  win_mask  [NWIN],
  input  word_t  win_tbase [NWIN],
  output match_t res
);
  localparam word_t OUT_MASK = {{(WORD_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};

  logic [NWIN-1:0] take;
  word_t           dir_a [NWIN];
  word_t           pte_a [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_cmp
    word_t field;
    word_t cmpm;
    word_t keep;
    assign field    = win_mask[w] & CMP_FIELD;
    assign cmpm     = ~win_mask[w] & CMP_FIELD;
    assign keep     = field | DIRECT_LOW;
    assign take[w]  = ((bus & cmpm) == (win_base[w] & cmpm)) && win_base[w][EN_BIT];
    assign dir_a[w] = ((win_tbase[w] & ~keep) | (bus & keep)) & OUT_MASK;
    assign pte_a[w] = (win_tbase[w] & ~((field >> PTE_SHIFT) | PTE_LOW))
                    | ((bus & (field | SG_PAGE_BITS)) >> PTE_SHIFT);
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    res = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (take[i]) begin
        res.hit         = 1'b1;
        res.sg          = win_base[i][MODE_BIT];
        res.direct_addr = dir_a[i];
        res.pte_addr    = pte_a[i];
      end
    end
  end
endmodule

// File: rtl/dxl_ctrl.sv
module dxl_ctrl
  import dxl_pkg::*;
#(
  parameter int unsigned OUT_W = 34
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  output logic   req_ready,
  input  word_t  req_addr,
  input  match_t m,
  output logic   rsp_valid,
  input  logic   rsp_ready,
  output word_t  rsp_addr,
  output logic   mem_req_valid,
  input  logic   mem_req_ready,
  output word_t  mem_req_addr,
  input  logic   mem_rsp_valid,
  input  word_t  mem_rsp_data
);
  localparam word_t OUT_MASK = {{(WORD_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};

  xl_state_e state;
  word_t     bus_q;
  word_t     pte_q;
  word_t     result_q;
  word_t     sg_result;

  assign sg_result = (((mem_rsp_data & ~word_t'(1)) << PAGE_SHIFT) | (bus_q & SG_OFFS)) & OUT_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bus_q    <= '0;
      pte_q    <= '0;
      result_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          bus_q <= req_addr;
          if (m.hit && m.sg) begin
            pte_q <= m.pte_addr;
            state <= ST_FETCH;
          end else begin
            result_q <= m.hit ? m.direct_addr : req_addr;
            state    <= ST_RESP;
          end
        end
        ST_FETCH: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          result_q <= sg_result;
          state    <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_FETCH);
  assign mem_req_addr  = pte_q;
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_addr      = result_q;

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)));

  assert_memreq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_fast_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(m.hit && m.sg)) |=> rsp_valid);

  assert_sg_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && mem_rsp_valid) |=> rsp_valid);

  assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !m.hit) |=> (rsp_addr == $past(req_addr)));

  assert_snapshot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !mem_rsp_valid) |=> $stable(bus_q));
endmodule

// File: rtl/dma_window_xlate.sv
module dma_window_xlate
  import dxl_pkg::*;
#(
  parameter int unsigned NWIN    = 4,
  parameter int unsigned OUT_W   = 34,
  parameter int unsigned SPACE_W = 12,
  parameter int unsigned IDX_LSB = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [SPACE_W-1:0] reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [63:0]        req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [63:0]        rsp_addr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [63:0]        mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [63:0]        mem_rsp_data
);
  word_t  wb [NWIN];
  word_t  wm [NWIN];
  word_t  wt [NWIN];
  match_t hit_info;

  dxl_regs #(.NWIN(NWIN), .SPACE_W(SPACE_W), .IDX_LSB(IDX_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .win_base(wb), .win_mask(wm), .win_tbase(wt)
  );

  dxl_match #(.NWIN(NWIN), .OUT_W(OUT_W)) u_match (
    .bus(req_addr), .win_base(wb), .win_mask(wm), .win_tbase(wt), .res(hit_info)
  );

  dxl_ctrl #(.OUT_W(OUT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .m(hit_info),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );
endmodule

// File: tb/dma_window_xlate_test.sv
`timescale 1ns/1ps
module dma_window_xlate_test;
  localparam logic [63:0] M34 = 64'h3_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_window_xlate uut (.*);

  function automatic logic [63:0] f_direct(input logic [63:0] m, t, bus);
    logic [63:0] k;
    k = (m & 64'hFFF0_0000) | 64'hF_FFFF;
    return ((t & ~k) | (bus & k)) & M34;
  endfunction

  function automatic logic [63:0] f_pte(input logic [63:0] m, t, bus);
    logic [63:0] f;
    f = m & 64'hFFF0_0000;
    return (t & ~((f >> 10) | 64'h3FF)) | ((bus & (f | 64'hFE000)) >> 10);
  endfunction

  function automatic logic [63:0] f_sg(input logic [63:0] d, bus);
    return (((d & ~64'h1) << 12) | (bus & 64'h1FFF)) & M34;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input int idx, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'((idx << 6) | 8); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rchk(input string tag, input int idx, input logic [63:0] exp);
    @(negedge clk);
    reg_addr = 12'((idx << 6) | 3);
    #1 chk(tag, reg_rdata, exp);
  endtask

  // direct / pass-through request with immediate consumer
  task automatic xlate(input string tag, input logic [63:0] bus, input logic [63:0] exp);
    @(negedge clk);
    chk({tag, " R11 idle ready"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = bus;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R10 valid next cycle"}, 64'(rsp_valid), 64'd1);
    chk({tag, " addr"}, rsp_addr, exp);
    @(negedge clk);
    chk({tag, " R11 released"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic sg_xlate(input string tag, input logic [63:0] bus, pte_exp, data, res_exp,
                          input int hold, input bit poke);
    @(negedge clk);
    mem_req_ready = (hold == 0);
    req_valid = 1'b1; req_addr = bus;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R6 mem req"}, 64'(mem_req_valid), 64'd1);
    chk({tag, " R6 pte addr"}, mem_req_addr, pte_exp);
    chk({tag, " R11 busy"}, 64'(req_ready), 64'd0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk({tag, " R6 held valid"}, 64'(mem_req_valid), 64'd1);
      chk({tag, " R6 held addr"}, mem_req_addr, pte_exp);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    chk({tag, " R6 one request"}, 64'(mem_req_valid), 64'd0);
    if (poke) begin
      wreg(10, 64'hFFFF_F000);
      wreg(2, 64'h0);
    end else begin
      @(negedge clk);
    end
    chk({tag, " R10 waits for entry"}, 64'(rsp_valid), 64'd0);
    mem_rsp_valid = 1'b1; mem_rsp_data = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk({tag, " R10 valid after entry"}, 64'(rsp_valid), 64'd1);
    chk({tag, " R7 result"}, rsp_addr, res_exp);
    @(negedge clk);
    chk({tag, " R11 released"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    for (int i = 0; i < 12; i++) rchk("R1 reg zero", i, 64'd0);
  endtask

  task automatic t_regs;
    for (int i = 0; i < 12; i++) wreg(i, 64'hA5A5_0000_0000_0000 | 64'(i * 17 + 3));
    wreg(13, 64'hDEAD_BEEF);
    wreg(63, 64'hDEAD_BEEF);
    for (int i = 0; i < 12; i++) rchk("R2 readback", i, 64'hA5A5_0000_0000_0000 | 64'(i * 17 + 3));
    rchk("R2 unmapped 13", 13, 64'd0);
    rchk("R2 unmapped 63", 63, 64'd0);
    for (int i = 0; i < 12; i++) wreg(i, 64'd0);
  endtask

  task automatic t_pass;
    xlate("R9 pass wide", 64'h0000_00AB_CDEF_1234, 64'h0000_00AB_CDEF_1234);
  endtask

  task automatic t_direct;
    wreg(0, 64'h4000_0001); wreg(4, 64'h0FF0_0000); wreg(8, 64'h1_2000_0000);
    xlate("R5 R3 direct", 64'h4567_89AB, f_direct(64'h0FF0_0000, 64'h1_2000_0000, 64'h4567_89AB));
    xlate("R3 R9 miss", 64'h5000_0000, 64'h5000_0000);
  endtask

  task automatic t_prio;
    wreg(1, 64'h4000_0001); wreg(5, 64'h0FF0_0000); wreg(9, 64'h2_0000_0000);
    xlate("R4 lowest wins", 64'h4123_4567, f_direct(64'h0FF0_0000, 64'h1_2000_0000, 64'h4123_4567));
    wreg(0, 64'h4000_0000);
    xlate("R4 disabled falls through", 64'h4123_4567,
          f_direct(64'h0FF0_0000, 64'h2_0000_0000, 64'h4123_4567));
  endtask

  task automatic t_trunc;
    wreg(3, 64'hC000_0001); wreg(7, 64'hFFFF_0000_3FF0_0000); wreg(11, 64'hFFFF_FFFF_0000_0000);
    xlate("R8 R3 truncate", 64'hC123_4567,
          f_direct(64'hFFFF_0000_3FF0_0000, 64'hFFFF_FFFF_0000_0000, 64'hC123_4567));
  endtask

  task automatic t_sg;
    wreg(2, 64'h8000_0003); wreg(6, 64'h0010_0000); wreg(10, 64'h0012_3000);
    sg_xlate("R6 sg", 64'h8015_4321, f_pte(64'h0010_0000, 64'h0012_3000, 64'h8015_4321),
             64'h0004_5671, f_sg(64'h0004_5671, 64'h8015_4321), 0, 1'b0);
    sg_xlate("R6 sg stalled", 64'h801F_FFFF, f_pte(64'h0010_0000, 64'h0012_3000, 64'h801F_FFFF),
             64'hFFF0_0000_0ABC_DEF0, f_sg(64'hFFF0_0000_0ABC_DEF0, 64'h801F_FFFF), 3, 1'b0);
  endtask

  task automatic t_midwrite;
    sg_xlate("R12 write in flight", 64'h8002_6000,
             f_pte(64'h0010_0000, 64'h0012_3000, 64'h8002_6000),
             64'h0000_0777, f_sg(64'h0000_0777, 64'h8002_6000), 0, 1'b1);
    xlate("R12 next uses new regs", 64'h8002_6000, 64'h8002_6000);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 64'h7777_0000;
    @(negedge clk);
    req_addr = 64'h7777_1111;
    for (int i = 0; i < 3; i++) begin
      chk("R11 rsp held", 64'(rsp_valid), 64'd1);
      chk("R11 addr held", rsp_addr, 64'h7777_0000);
      chk("R11 no new accept", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    req_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 drained", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_pass();
    t_direct();
    t_prio();
    t_trunc();
    t_sg();
    t_midwrite();
    t_backpressure();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule